// File: doc/BRIEF.md
# Neighbor Tag Cache for a DRAM Cache Bank

Each read burst from a DRAM cache bank that stores tag and data side by side returns a little more than the line asked for. It carries the requested unit's tag and its 64 data bytes. It also carries the tag field of the next unit in the same DRAM row. This block keeps that extra tag in a tiny per-bank table. A later request for the neighbor set can then be settled without a tag read on the DRAM cache bus.

On each response beat the block records the neighbor's set index, its stored tag and that line's valid bit. A lookup then gives one of three answers:
- a definite hit, when the tag matches and the line is valid;
- a definite miss, when the tag differs or the line is invalid;
- unknown, when no entry covers the set. In that case the normal tag read proceeds.

Fills and writebacks into a set remove any entry that covers that set, so stale tags are never reported.

Top module: `nbr_tag_cache`

## Requirements
- R1: After reset no entry is held: `res_valid` is 0 and every lookup returns unknown until a capture occurs.
- R2: A response for set s records an entry for set s+1 holding `resp_nbr_tag` and `resp_nbr_lv`. A later lookup of set s+1 with an equal tag, while the recorded valid bit is 1, returns hit (code 2).
- R3: A lookup that finds an entry for its set returns miss (code 1) when the tags differ or when the recorded valid bit is 0.
- R4: A lookup whose set is covered by no entry returns unknown (code 0). Code 3 is never produced.
- R5: A response for the last unit of a row (set mod UNITS_PER_ROW equal to UNITS_PER_ROW-1) records nothing.
- R6: The table has ENTRIES slots, filled in strict round-robin order. Once all slots have been written, a new set replaces the slot written longest ago, whether or not any slot was freed by an update.
- R7: A capture for a set that a live entry already holds rewrites that entry in place and does not advance the round-robin pointer.
- R8: An update (`upd_valid`, a fill or writeback of `upd_set`) removes the entry for that set. Lookups from the next cycle on return unknown for it.
- R9: When a capture and an update name the same neighbor set in the same cycle, the update wins and no entry is left for that set.
- R10: A lookup made in the same cycle as an update of the same set returns unknown.
- R11: The result of a lookup appears on `res_valid`/`res_code` exactly one cycle later and is judged on the table as it stood before that cycle's capture or update. `res_valid` is 0 in cycles that follow no lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resp_valid | input | 1 | Demand response beat present |
| resp_set | input | SET_W | Set index of the demanded unit |
| resp_nbr_tag | input | TAG_W | Tag field of the next unit in the row |
| resp_nbr_lv | input | 1 | Valid bit of the next unit |
| upd_valid | input | 1 | Fill or writeback into a set this cycle |
| upd_set | input | SET_W | Set index being written |
| lk_valid | input | 1 | Lookup request |
| lk_set | input | SET_W | Set index looked up |
| lk_tag | input | TAG_W | Tag of the requested line |
| res_valid | output | 1 | Lookup result present |
| res_code | output | 2 | 0 unknown, 1 miss, 2 hit |

## Verification
The assertions take several things for granted. At most one response, one update and one lookup arrive per cycle. The response set index is never the all-ones value. `lk_valid` is held low during reset, so that the one-cycle result relation starts clean. The stimulus keeps to these assumptions: it drives every input from a single task after the falling edge, and it draws set indices from a small range that crosses row boundaries but never reaches the top of the index space. Within that range, it deliberately overlaps captures, updates and lookups on the same set.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
  typedef enum logic [1:0] {
    NTC_UNKNOWN = 2'd0,
    NTC_MISS    = 2'd1,
    NTC_HIT     = 2'd2
  } ntc_res_e;
endpackage

// File: rtl/ntc_capture_gate.sv
module ntc_capture_gate #(
  parameter int SET_W         = 20,
  parameter int UNITS_PER_ROW = 28
) (
  input  logic             resp_valid,
  input  logic [SET_W-1:0] resp_set,
  input  logic             upd_valid,
  input  logic [SET_W-1:0] upd_set,
  output logic             cap_en,
  output logic [SET_W-1:0] cap_set
);
  localparam logic [SET_W-1:0] ROW_UNITS = SET_W'(UNITS_PER_ROW);
  localparam logic [SET_W-1:0] LAST_POS  = SET_W'(UNITS_PER_ROW - 1);

  logic row_end;

  always_comb begin
    row_end = ((resp_set % ROW_UNITS) == LAST_POS) || (resp_set == '1);
    cap_set = resp_set + SET_W'(1);
    // an update of the neighbor set in the same cycle suppresses the capture
    cap_en  = resp_valid && !row_end && !(upd_valid && (upd_set == cap_set));
  end
endmodule

// File: rtl/ntc_entry_file.sv
module ntc_entry_file #(
  parameter int SET_W   = 20,
  parameter int TAG_W   = 32,
  parameter int ENTRIES = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cap_en,
  input  logic [SET_W-1:0]                cap_set,
  input  logic [TAG_W-1:0]                cap_tag,
  input  logic                            cap_lv,
  input  logic                            inv_en,
  input  logic [SET_W-1:0]                inv_set,
  output logic [ENTRIES-1:0]              ent_used,
  output logic [ENTRIES-1:0][SET_W-1:0]   ent_set,
  output logic [ENTRIES-1:0][TAG_W-1:0]   ent_tag,
  output logic [ENTRIES-1:0]              ent_lv
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0]   ptr;
  logic [IDX_W-1:0]   tgt;
  logic [ENTRIES-1:0] same_vec;
  logic               same_any;

  always_comb begin
    tgt = ptr;
    for (int i = 0; i < ENTRIES; i++) begin
      same_vec[i] = ent_used[i] && (ent_set[i] == cap_set);
      if (same_vec[i]) tgt = IDX_W'(i);
    end
    same_any = |same_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_used <= '0;
      ptr      <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_en && ent_used[i] && (ent_set[i] == inv_set)) ent_used[i] <= 1'b0;
        if (cap_en && (tgt == IDX_W'(i))) ent_used[i] <= 1'b1;
      end
      if (cap_en && !same_any) ptr <= (ptr == LAST_IDX) ? '0 : ptr + IDX_W'(1);
    end
  end

  // payload array carries no reset so it maps onto plain storage
  always_ff @(posedge clk) begin
    if (cap_en) begin
      ent_set[tgt] <= cap_set;
      ent_tag[tgt] <= cap_tag;
      ent_lv[tgt]  <= cap_lv;
    end
  end

  logic             inv_q;
  logic [SET_W-1:0] inv_set_q;
  logic             inv_left;
  always_ff @(posedge clk) begin
    if (rst) begin
      inv_q     <= 1'b0;
      inv_set_q <= '0;
    end else begin
      inv_q     <= inv_en;
      inv_set_q <= inv_set;
    end
  end
  always_comb begin
    inv_left = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (ent_used[i] && (ent_set[i] == inv_set_q)) inv_left = 1'b1;
  end

  // R8
  inv_clears_chk: assert property (@(posedge clk) disable iff (rst) inv_q |-> !inv_left);

  // R7
  recap_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_en && same_any && !inv_en) |=> ($countones(ent_used) == $countones($past(ent_used))));

  genvar gi, gj;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_a
      for (gj = gi + 1; gj < ENTRIES; gj++) begin : g_b
        // R7
        no_dup_set_chk: assert property (@(posedge clk) disable iff (rst)
          (ent_used[gi] && ent_used[gj]) |-> (ent_set[gi] != ent_set[gj]));
      end
    end
  endgenerate
endmodule

// File: rtl/ntc_lookup.sv
module ntc_lookup
  import ntc_pkg::*;
#(
  parameter int SET_W   = 20,
  parameter int TAG_W   = 32,
  parameter int ENTRIES = 4
) (
  input  logic [ENTRIES-1:0]            ent_used,
  input  logic [ENTRIES-1:0][SET_W-1:0] ent_set,
  input  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag,
  input  logic [ENTRIES-1:0]            ent_lv,
  input  logic [SET_W-1:0]              lk_set,
  input  logic [TAG_W-1:0]              lk_tag,
  input  logic                          inv_en,
  input  logic [SET_W-1:0]              inv_set,
  output ntc_res_e                      code
);
  always_comb begin
    code = NTC_UNKNOWN;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_used[i] && (ent_set[i] == lk_set))
        code = (ent_lv[i] && (ent_tag[i] == lk_tag)) ? NTC_HIT : NTC_MISS;
    end
    if (inv_en && (inv_set == lk_set)) code = NTC_UNKNOWN;
  end
endmodule

// File: rtl/nbr_tag_cache.sv
module nbr_tag_cache
  import ntc_pkg::*;
#(
  parameter int SET_W         = 20,
  parameter int TAG_W         = 32,
  parameter int ENTRIES       = 4,
  parameter int UNITS_PER_ROW = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             resp_valid,
  input  logic [SET_W-1:0] resp_set,
  input  logic [TAG_W-1:0] resp_nbr_tag,
  input  logic             resp_nbr_lv,
  input  logic             upd_valid,
  input  logic [SET_W-1:0] upd_set,
  input  logic             lk_valid,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             res_valid,
  output logic [1:0]       res_code
);
  logic                          cap_en;
  logic [SET_W-1:0]              cap_set;
  logic [ENTRIES-1:0]            ent_used;
  logic [ENTRIES-1:0][SET_W-1:0] ent_set;
  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag;
  logic [ENTRIES-1:0]            ent_lv;
  ntc_res_e                      lk_code;

  ntc_capture_gate #(.SET_W(SET_W), .UNITS_PER_ROW(UNITS_PER_ROW)) u_gate (
    .resp_valid(resp_valid), .resp_set(resp_set),
    .upd_valid(upd_valid), .upd_set(upd_set),
    .cap_en(cap_en), .cap_set(cap_set)
  );

  ntc_entry_file #(.SET_W(SET_W), .TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_file (
    .clk(clk), .rst(rst),
    .cap_en(cap_en), .cap_set(cap_set), .cap_tag(resp_nbr_tag), .cap_lv(resp_nbr_lv),
    .inv_en(upd_valid), .inv_set(upd_set),
    .ent_used(ent_used), .ent_set(ent_set), .ent_tag(ent_tag), .ent_lv(ent_lv)
  );

  ntc_lookup #(.SET_W(SET_W), .TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_look (
    .ent_used(ent_used), .ent_set(ent_set), .ent_tag(ent_tag), .ent_lv(ent_lv),
    .lk_set(lk_set), .lk_tag(lk_tag), .inv_en(upd_valid), .inv_set(upd_set),
    .code(lk_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_code  <= 2'd0;
    end else begin
      res_valid <= lk_valid;
      res_code  <= lk_valid ? lk_code : 2'd0;
    end
  end

  localparam logic [SET_W-1:0] ROW_UNITS = SET_W'(UNITS_PER_ROW);
  logic resp_row_end;
  assign resp_row_end = (resp_set % ROW_UNITS) == SET_W'(UNITS_PER_ROW - 1);

  // R11
  res_follows_lk_chk: assert property (@(posedge clk) disable iff (rst) lk_valid |=> res_valid);
  // R11
  res_idle_chk: assert property (@(posedge clk) disable iff (rst) !lk_valid |=> !res_valid);
  // R4
  res_code_legal_chk: assert property (@(posedge clk) disable iff (rst) res_valid |-> (res_code != 2'd3));
  // R5
  row_end_no_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_row_end && !upd_valid) |=> $stable(ent_used));
  // R10
  upd_same_lk_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && upd_valid && (upd_set == lk_set)) |=> (res_code == 2'd0));
endmodule

// File: tb/sim_nbr_tag_cache.sv
`timescale 1ns/1ps
module sim_nbr_tag_cache;
  localparam int SW = 20;
  localparam int TW = 32;
  localparam int NE = 4;
  localparam int UPR = 28;

  logic clk = 1'b0;
  logic rst;
  logic resp_valid, resp_nbr_lv, upd_valid, lk_valid;
  logic [SW-1:0] resp_set, upd_set, lk_set;
  logic [TW-1:0] resp_nbr_tag, lk_tag;
  logic res_valid;
  logic [1:0] res_code;

  always #4 clk = ~clk;

  nbr_tag_cache #(.SET_W(SW), .TAG_W(TW), .ENTRIES(NE), .UNITS_PER_ROW(UPR)) u0 (
    .clk(clk), .rst(rst),
    .resp_valid(resp_valid), .resp_set(resp_set), .resp_nbr_tag(resp_nbr_tag),
    .resp_nbr_lv(resp_nbr_lv), .upd_valid(upd_valid), .upd_set(upd_set),
    .lk_valid(lk_valid), .lk_set(lk_set), .lk_tag(lk_tag),
    .res_valid(res_valid), .res_code(res_code)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  bit  m_used[NE];
  int  m_set[NE];
  int  m_tag[NE];
  bit  m_lv[NE];
  int  m_ptr;

  task automatic report(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: drive, let the model follow the edge, compare after it
  task automatic step(bit rv, int rs, int rt, bit rl, bit uv, int us,
                      bit lv, int ls, int lt, string req);
    bit ev; int ec; int n; int hitk;
    resp_valid = rv; resp_set = SW'(rs); resp_nbr_tag = TW'(rt); resp_nbr_lv = rl;
    upd_valid = uv; upd_set = SW'(us);
    lk_valid = lv; lk_set = SW'(ls); lk_tag = TW'(lt);
    @(posedge clk);
    ev = lv; ec = 0;
    for (int k = 0; k < NE; k++)
      if (m_used[k] && m_set[k] == ls) ec = (m_lv[k] && m_tag[k] == lt) ? 2 : 1;
    if (uv && us == ls) ec = 0;
    n = rs + 1;
    hitk = -1;
    for (int k = 0; k < NE; k++) if (m_used[k] && m_set[k] == n) hitk = k;
    if (uv) for (int k = 0; k < NE; k++) if (m_used[k] && m_set[k] == us) m_used[k] = 0;
    if (rv && (rs % UPR) != UPR - 1 && !(uv && us == n)) begin
      if (hitk < 0) begin hitk = m_ptr; m_ptr = (m_ptr + 1) % NE; end
      m_used[hitk] = 1; m_set[hitk] = n; m_tag[hitk] = rt; m_lv[hitk] = rl;
    end
    @(negedge clk);
    report(res_valid == ev, req, "res_valid", int'(res_valid), int'(ev));
    if (ev) report(int'(res_code) == ec, req, "res_code", int'(res_code), ec);
  endtask

  task automatic idle(string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NE; k++) begin m_used[k] = 0; m_set[k] = 0; m_tag[k] = 0; m_lv[k] = 0; end
    m_ptr = 0;
    rst = 1'b1;
    resp_valid = 0; resp_set = '0; resp_nbr_tag = '0; resp_nbr_lv = 0;
    upd_valid = 0; upd_set = '0; lk_valid = 0; lk_set = '0; lk_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    report(res_valid == 1'b0, "R1", "res_valid in reset", int'(res_valid), 0);
    rst = 1'b0;
    // R1: empty table answers unknown
    step(0, 0, 0, 0, 0, 0, 1, 1, 5, "R1");
    // R2: capture for set 0 then hit on set 1
    step(1, 0, 'h111, 1, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 1, 1, 'h111, "R2");
    // R3: tag differs, then recorded invalid line
    step(0, 0, 0, 0, 0, 0, 1, 1, 'h222, "R3");
    step(1, 4, 'h333, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 1, 5, 'h333, "R3");
    // R4: uncovered set
    step(0, 0, 0, 0, 0, 0, 1, 9, 'h1, "R4");
    // R5: last unit of a row
    step(1, 27, 'h444, 1, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 1, 28, 'h444, "R5");
    // R6: fill remaining slots, fifth distinct set evicts set 1
    step(1, 10, 'h555, 1, 0, 0, 0, 0, 0, "R6");
    step(1, 12, 'h666, 1, 0, 0, 0, 0, 0, "R6");
    step(1, 14, 'h777, 1, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 1, 'h111, "R6");
    step(0, 0, 0, 0, 0, 0, 1, 15, 'h777, "R6");
    // R7: rewrite set 5 in place; next new set evicts set 5, set 11 survives
    step(1, 4, 'h333, 1, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 5, 'h333, "R7");
    step(1, 20, 'h888, 1, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 11, 'h555, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 5, 'h333, "R7");
    // R8: update removes entry
    step(0, 0, 0, 0, 1, 11, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 11, 'h555, "R8");
    // R9: capture and update of same neighbor set
    step(1, 30, 'h999, 1, 1, 31, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 31, 'h999, "R9");
    // R10: lookup during update of that set
    step(0, 0, 0, 0, 1, 13, 1, 13, 'h666, "R10");
    step(0, 0, 0, 0, 0, 0, 1, 13, 'h666, "R10");
    // R11: lookup sees the table before same-cycle capture
    step(1, 40, 'hAAA, 1, 0, 0, 1, 41, 'hAAA, "R11");
    step(0, 0, 0, 0, 0, 0, 1, 41, 'hAAA, "R11");
    idle("R11");
    // mixed traffic across row boundaries
    for (int c = 0; c < 600; c++) begin
      int rs = $urandom_range(0, 60);
      int us = $urandom_range(0, 61);
      int ls = $urandom_range(0, 61);
      int tg = $urandom_range(0, 3);
      step(1'($urandom_range(0, 1)), rs, tg, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 3) == 0), us,
           1'($urandom_range(0, 1)), ls, $urandom_range(0, 3), "R11");
    end
    finish_run();
  end
endmodule